// File: doc/BRIEF.md
# UART FIFO Trigger and Interrupt Identifier

This block sits beside the receive and transmit FIFOs of a UART and decides when those FIFOs need service. It compares each FIFO's occupancy count against a programmable trigger level and raises level-sensitive DMA requests. It also watches the receive FIFO for a character timeout. It gathers the interrupt sources into one interrupt line and a 4-bit identifier that names the most urgent pending cause.

Trigger levels come in two encodings. The coarse encoding takes a 2-bit code that selects a fraction of the FIFO depth. The fine encoding takes a 5-bit byte count. The receive timeout counts character-time ticks, which a baud generator supplies. The count restarts whenever the receive FIFO is pushed or popped, or is empty.

Line-status and modem-status events are held in sticky flags until a clear strobe arrives. Transmit-slot and receive-data causes are levels, so they clear when the FIFO state changes. The FIFOs and the serial shift engines live elsewhere.

Top module: `uart_fifo_event_ctl`

## Requirements
- R1: With fine_mode low, the TX trigger (seen on tx_dma_req when dma_en is high) is active when tx_count is below a limit picked by tx_level[1:0]. Code 0 selects DEPTH, code 1 selects 3/4 DEPTH, code 2 selects 1/2 DEPTH and code 3 selects 1/4 DEPTH. For DEPTH 32 these limits are 32, 24, 16 and 8.
- R2: With fine_mode low, the RX trigger is active when rx_count exceeds a bound picked by rx_level[1:0]. Code 0 selects 0, code 1 selects DEPTH/4-1, code 2 selects DEPTH/2-1 and code 3 selects DEPTH-DEPTH/8-1. For DEPTH 32 these bounds are 0, 7, 15 and 27.
- R3: With fine_mode high, the TX trigger is active when tx_count <= tx_level, and the RX trigger is active when rx_count > rx_level (5-bit levels).
- R4: rx_dma_req and tx_dma_req equal dma_en ANDed with the matching trigger, one clock after the inputs. Both are low while dma_en is low.
- R5: The receive timeout becomes pending once rx_count is nonzero and 4 char_tick pulses have arrived with no rx_push or rx_pop. A push or a pop restarts the count, and so does an empty FIFO.
- R6: irq_id codes are line status 0x6, RX data available 0x4, RX timeout 0xC, TX slot 0x2 and modem status 0x0. Priority from highest to lowest is line status, RX data available, RX timeout, TX slot, then modem status.
- R7: When no enabled cause is pending, irq_id reads 0x1 and irq is low. A cause whose enable is low has no effect on irq or irq_id. en_rx gates both data available and timeout.
- R8: The RX data-available cause stays pending while reads lower the occupancy but it still meets the RX trigger. It drops only once the occupancy falls below the threshold.
- R9: The TX slot cause is pending exactly when tx_count is zero, whatever the TX trigger level.
- R10: line_evt and modem_evt set sticky flags that stay set until line_clr and modem_clr respectively. An event in the same cycle as its clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | 6 | RX FIFO occupancy |
| tx_count | input | 6 | TX FIFO occupancy |
| rx_push | input | 1 | Character written into RX FIFO |
| rx_pop | input | 1 | Character read from RX FIFO |
| char_tick | input | 1 | One pulse per character time |
| line_evt | input | 1 | Receive line error event |
| line_clr | input | 1 | Clear line-status flag |
| modem_evt | input | 1 | Modem input change event |
| modem_clr | input | 1 | Clear modem-status flag |
| fine_mode | input | 1 | 1: per-byte levels, 0: quarter codes |
| tx_level | input | 5 | TX trigger level |
| rx_level | input | 5 | RX trigger level |
| dma_en | input | 1 | Enable DMA requests |
| en_rx | input | 1 | Enable RX data/timeout interrupt |
| en_tx | input | 1 | Enable TX slot interrupt |
| en_line | input | 1 | Enable line-status interrupt |
| en_modem | input | 1 | Enable modem-status interrupt |
| rx_dma_req | output | 1 | RX DMA request (level) |
| tx_dma_req | output | 1 | TX DMA request (level) |
| irq | output | 1 | Interrupt line |
| irq_id | output | 4 | Highest-priority pending cause |

## Verification
The bench walks each coarse code and several fine levels across their exact boundary counts, one byte either side. An off-by-one in the comparator would move a request by one byte, and a swapped code table would show the wrong fraction. The timeout is probed at three ticks and at four, after a pop, and with an empty FIFO. A counter that failed to restart, or that ran while the FIFO was empty, would report a timeout early or spuriously. Priority is checked by stacking causes and then removing them one at a time, which exposes a misordered encoder. The data-available cause is drained byte by byte, which exposes a design that drops it on the first read.

// File: rtl/uart_fifo_event_pkg.sv
package uart_fifo_event_pkg;

    typedef enum logic [3:0] {
        IRQ_MODEM  = 4'h0,
        IRQ_NONE   = 4'h1,
        IRQ_TXSLOT = 4'h2,
        IRQ_RXDATA = 4'h4,
        IRQ_LINE   = 4'h6,
        IRQ_RXTO   = 4'hC
    } irq_code_e;

    typedef struct packed {
        logic rx_hit;
        logic tx_hit;
        logic rx_dma;
        logic tx_dma;
    } trig_state_t;

    typedef struct packed {
        logic      line;
        logic      modem;
        irq_code_e id;
        logic      irq;
    } sel_state_t;

endpackage

// File: rtl/uart_lvl_cmp.sv
module uart_lvl_cmp #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6,
    parameter int LVL_W = 5,
    parameter bit IS_RX = 1'b0
) (
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] level,
    input  logic             fine,
    output logic             hit
);
    localparam int Q1 = DEPTH / 4;
    localparam int Q2 = DEPTH / 2;
    localparam int Q3 = (3 * DEPTH) / 4;
    localparam int E7 = DEPTH - DEPTH / 8;

    int cnt_i;
    int lvl_i;
    assign cnt_i = int'(count);
    assign lvl_i = int'(level);

    generate
        if (IS_RX) begin : g_rx
            always_comb begin
                if (fine) begin
                    hit = cnt_i > lvl_i;
                end else begin
                    unique case (level[1:0])
                        2'd0:    hit = cnt_i > 0;
                        2'd1:    hit = cnt_i > Q1 - 1;
                        2'd2:    hit = cnt_i > Q2 - 1;
                        default: hit = cnt_i > E7 - 1;
                    endcase
                end
            end
        end else begin : g_tx
            always_comb begin
                if (fine) begin
                    hit = cnt_i <= lvl_i;
                end else begin
                    unique case (level[1:0])
                        2'd0:    hit = cnt_i < DEPTH;
                        2'd1:    hit = cnt_i < Q3;
                        2'd2:    hit = cnt_i < Q2;
                        default: hit = cnt_i < Q1;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/uart_rx_char_timer.sv
module uart_rx_char_timer #(
    parameter int CNT_W    = 6,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    output logic             timeout
);
    localparam int TO_W = $clog2(TO_CHARS + 1);
    localparam logic [TO_W-1:0] TO_LIM = TO_W'(TO_CHARS);

    typedef struct packed {
        logic [TO_W-1:0] ticks;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic empty;

    assign empty = (rx_count == '0);

    always_comb begin
        st_d = st_q;
        if (rx_push || rx_pop || empty) begin
            st_d.ticks = '0;
        end else if (char_tick && st_q.ticks != TO_LIM) begin
            st_d.ticks = st_q.ticks + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timeout = (st_q.ticks == TO_LIM) && !empty;

    assert_to_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !timeout);
    assert_to_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout && !char_tick) |=> !timeout);
endmodule

// File: rtl/uart_irq_sel.sv
module uart_irq_sel
    import uart_fifo_event_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_avail,
    input  logic      rx_tmo,
    input  logic      tx_empty,
    input  logic      line_evt,
    input  logic      line_clr,
    input  logic      modem_evt,
    input  logic      modem_clr,
    input  logic      en_rx,
    input  logic      en_tx,
    input  logic      en_line,
    input  logic      en_modem,
    output logic      irq,
    output irq_code_e irq_id
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // sticky flags: event beats clear
        if (line_evt)       st_d.line = 1'b1;
        else if (line_clr)  st_d.line = 1'b0;
        if (modem_evt)      st_d.modem = 1'b1;
        else if (modem_clr) st_d.modem = 1'b0;

        st_d.irq = 1'b1;
        if (en_line && st_q.line)         st_d.id = IRQ_LINE;
        else if (en_rx && rx_avail)       st_d.id = IRQ_RXDATA;
        else if (en_rx && rx_tmo)         st_d.id = IRQ_RXTO;
        else if (en_tx && tx_empty)       st_d.id = IRQ_TXSLOT;
        else if (en_modem && st_q.modem)  st_d.id = IRQ_MODEM;
        else begin
            st_d.id  = IRQ_NONE;
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line  <= 1'b0;
            st_q.modem <= 1'b0;
            st_q.id    <= IRQ_NONE;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq    = st_q.irq;
    assign irq_id = st_q.id;

    assert_line_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_line && st_q.line) |=> (irq_id == IRQ_LINE));
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_line && !en_rx && !en_tx && !en_modem) |=> (!irq && irq_id == IRQ_NONE));
    assert_tx_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_tx && tx_empty && !en_line && !en_rx) |=> (irq_id == IRQ_TXSLOT));
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt |=> st_q.line);
endmodule

// File: rtl/uart_fifo_event_ctl.sv
module uart_fifo_event_ctl
    import uart_fifo_event_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int LVL_W    = 5,
    parameter int TO_CHARS = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic             line_evt,
    input  logic             line_clr,
    input  logic             modem_evt,
    input  logic             modem_clr,
    input  logic             fine_mode,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             dma_en,
    input  logic             en_rx,
    input  logic             en_tx,
    input  logic             en_line,
    input  logic             en_modem,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             irq,
    output logic [3:0]       irq_id
);
    trig_state_t st_d, st_q;
    logic rx_cmp, tx_cmp, rx_tmo;
    irq_code_e id_e;

    uart_lvl_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W), .IS_RX(1'b1)) i_rx_cmp (
        .count(rx_count), .level(rx_level), .fine(fine_mode), .hit(rx_cmp));

    uart_lvl_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W), .IS_RX(1'b0)) i_tx_cmp (
        .count(tx_count), .level(tx_level), .fine(fine_mode), .hit(tx_cmp));

    uart_rx_char_timer #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) i_timer (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_push(rx_push),
        .rx_pop(rx_pop), .char_tick(char_tick), .timeout(rx_tmo));

    always_comb begin
        st_d        = st_q;
        st_d.rx_hit = rx_cmp;
        st_d.tx_hit = tx_cmp;
        st_d.rx_dma = dma_en && rx_cmp;
        st_d.tx_dma = dma_en && tx_cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    uart_irq_sel i_sel (
        .clk(clk), .rst_n(rst_n),
        .rx_avail(st_q.rx_hit), .rx_tmo(rx_tmo), .tx_empty(tx_count == '0),
        .line_evt(line_evt), .line_clr(line_clr),
        .modem_evt(modem_evt), .modem_clr(modem_clr),
        .en_rx(en_rx), .en_tx(en_tx), .en_line(en_line), .en_modem(en_modem),
        .irq(irq), .irq_id(id_e));

    assign irq_id     = id_e;
    assign rx_dma_req = st_q.rx_dma;
    assign tx_dma_req = st_q.tx_dma;

    assert_dma_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> (!rx_dma_req && !tx_dma_req));
    assert_rx_empty_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !rx_dma_req);
    assert_tx_full_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fine_mode && tx_count == CNT_W'(DEPTH)) |=> !tx_dma_req);
    assert_id_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_id inside {4'h0, 4'h2, 4'h4, 4'h6, 4'hC}));
endmodule

// File: tb/test_uart_fifo_event_ctl.sv
module test_uart_fifo_event_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] rx_count = '0, tx_count = '0;
    logic rx_push = 0, rx_pop = 0, char_tick = 0;
    logic line_evt = 0, line_clr = 0, modem_evt = 0, modem_clr = 0;
    logic fine_mode = 0, dma_en = 0;
    logic [4:0] tx_level = '0, rx_level = '0;
    logic en_rx = 0, en_tx = 0, en_line = 0, en_modem = 0;
    logic rx_dma_req, tx_dma_req, irq;
    logic [3:0] irq_id;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_fifo_event_ctl i_uart_fifo_event_ctl (.*);

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic t_reset();
        check("R7 reset id", irq_id, 4'h1);
        check("R7 reset irq", irq, 0);
        check("R4 reset dma", {rx_dma_req, tx_dma_req}, 0);
    endtask

    task automatic t_coarse_tx();
        int lim[4] = '{32, 24, 16, 8};
        fine_mode = 0; dma_en = 1;
        for (int c = 0; c < 4; c++) begin
            tx_level = 5'(c);
            tx_count = 6'(lim[c] - 1); settle();
            check("R1 below limit", tx_dma_req, 1);
            tx_count = 6'(lim[c]); settle();
            check("R1 at limit", tx_dma_req, 0);
        end
    endtask

    task automatic t_coarse_rx();
        int bnd[4] = '{0, 7, 15, 27};
        fine_mode = 0; dma_en = 1;
        for (int c = 0; c < 4; c++) begin
            rx_level = 5'(c);
            rx_count = 6'(bnd[c]); settle();
            check("R2 at bound", rx_dma_req, 0);
            rx_count = 6'(bnd[c] + 1); settle();
            check("R2 above bound", rx_dma_req, 1);
        end
        rx_count = 0;
    endtask

    task automatic t_fine();
        int lv[3] = '{0, 13, 31};
        fine_mode = 1; dma_en = 1;
        for (int i = 0; i < 3; i++) begin
            tx_level = 5'(lv[i]); rx_level = 5'(lv[i]);
            tx_count = 6'(lv[i]); rx_count = 6'(lv[i]); settle();
            check("R3 tx at N", tx_dma_req, 1);
            check("R3 rx at N", rx_dma_req, 0);
            tx_count = 6'(lv[i] + 1); rx_count = 6'(lv[i] + 1); settle();
            check("R3 tx above N", tx_dma_req, 0);
            check("R3 rx above N", rx_dma_req, 1);
        end
        fine_mode = 0; rx_count = 0;
    endtask

    task automatic t_dma_gate();
        fine_mode = 0; tx_level = 0; rx_level = 0;
        tx_count = 3; rx_count = 3; dma_en = 0; settle();
        check("R4 gated off", {rx_dma_req, tx_dma_req}, 0);
        dma_en = 1;
        @(posedge clk); @(negedge clk);
        check("R4 one cycle", {rx_dma_req, tx_dma_req}, 2'b11);
        rx_count = 0;
    endtask

    task automatic t_timeout();
        en_rx = 1; en_tx = 0; en_line = 0; en_modem = 0;
        fine_mode = 0; rx_level = 3; rx_count = 5;
        pulse(rx_push);
        repeat (3) pulse(char_tick);
        settle();
        check("R5 three ticks", irq_id, 4'h1);
        pulse(char_tick); settle();
        check("R5 four ticks", irq_id, 4'hC);
        pulse(rx_pop); settle();
        check("R5 pop restarts", irq_id, 4'h1);
        repeat (3) pulse(char_tick);
        pulse(rx_push);
        pulse(char_tick); settle();
        check("R5 push restarts", irq_id, 4'h1);
        rx_count = 0;
        repeat (6) pulse(char_tick); settle();
        check("R5 empty no timeout", irq_id, 4'h1);
        en_rx = 0;
    endtask

    task automatic t_persist();
        en_rx = 1; fine_mode = 0; rx_level = 1; rx_count = 10; settle();
        check("R8 avail", irq_id, 4'h4);
        for (int n = 9; n >= 8; n--) begin
            rx_count = 6'(n); pulse(rx_pop); settle();
            check("R8 still avail", irq_id, 4'h4);
        end
        rx_count = 7; pulse(rx_pop); settle();
        check("R8 dropped", irq_id, 4'h1);
        rx_count = 0; en_rx = 0;
    endtask

    task automatic t_txslot();
        en_tx = 1; fine_mode = 1; tx_level = 31; tx_count = 1; settle();
        check("R9 not empty", irq_id, 4'h1);
        tx_count = 0; settle();
        check("R9 empty", irq_id, 4'h2);
        check("R9 irq", irq, 1);
        fine_mode = 0; en_tx = 0; settle();
        check("R7 disabled tx ignored", irq, 0);
    endtask

    task automatic t_priority();
        en_rx = 1; en_tx = 1; en_line = 1; en_modem = 1;
        fine_mode = 0; rx_level = 0; tx_count = 0; rx_count = 0;
        pulse(modem_evt); settle();
        check("R6 tx over modem", irq_id, 4'h2);
        rx_count = 2; settle();
        check("R6 rx over tx", irq_id, 4'h4);
        pulse(line_evt); settle();
        check("R6 line top", irq_id, 4'h6);
        line_clr = 1; line_evt = 1;
        @(negedge clk); line_clr = 0; line_evt = 0; settle();
        check("R10 event beats clear", irq_id, 4'h6);
        pulse(line_clr); settle();
        check("R10 line cleared", irq_id, 4'h4);
        rx_count = 0; settle();
        check("R6 back to tx", irq_id, 4'h2);
        tx_count = 4; settle();
        check("R10 modem sticky", irq_id, 4'h0);
        en_modem = 0; settle();
        check("R7 modem masked", irq_id, 4'h1);
        en_modem = 1; pulse(modem_clr); settle();
        check("R10 modem cleared", irq_id, 4'h1);
        check("R7 irq low", irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_coarse_tx();
        t_coarse_rx();
        t_fine();
        t_dma_gate();
        t_timeout();
        t_persist();
        t_txslot();
        t_priority();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule